// File: doc/BRIEF.md
# UART Framing Engine

This block turns parallel characters into asynchronous serial frames and back. The transmit side takes a character from a FIFO through a pop strobe and sends a start bit, 5 to 8 data bits (least significant first), an optional parity bit and one or two stop bits. The receive side finds a start bit, samples every bit near its centre and pushes the character into a FIFO with parity, framing and break flags. A shared rate generator makes one enable tick every `baud_word + 1` clocks, and every serial bit spans 16 of those ticks.

Configuration inputs are plain levels that software is expected to hold steady while a character is in flight. A loopback control feeds the transmitter's line straight into the receiver and parks the external serial output high. A break control forces the serial line low and keeps new characters from starting. Separate enables gate the rate generator, the transmitter and the receiver.

Top module: `uart_frame_engine`

## Requirements
- R1: `char_len` selects the number of data bits as 5 + code (0 gives 5, 3 gives 8). Bits at or above that length in `tx_data` are not sent, and the same bits of `rx_data` read as zero.
- R2: `two_stop` = 1 makes the transmitter send two stop bits, otherwise one. A character waiting in the FIFO starts one tick after the last stop bit ends, so successive `tx_pop` strobes are (1 + length + parity + stops) x 16 x (baud_word + 1) + (baud_word + 1) clocks apart.
- R3: With `tx_par_en` = 1 a parity bit follows the data. `tx_par_even` = 1 makes the total count of ones in data plus parity even; 0 makes it odd.
- R4: With `rx_par_en` = 1 the receiver compares the received parity bit against the same rule (`rx_par_even`) and sets `rx_perr` on a mismatch.
- R5: Every transmitted bit lasts exactly 16 x (baud_word + 1) clocks, with the start bit going low on the clock edge at which `tx_pop` is high.
- R6: With `brg_en` = 0 no tick is made, so no character is popped or pushed. `tx_en` = 0 stops new characters from being popped, and `rx_en` = 0 stops start bits from being accepted.
- R7: While `tx_break` is 1, `txd` is low from the next clock on and no character is popped.
- R8: With `loopback` = 1 the receiver hears the transmitter's own line, characters come back unchanged and `txd` stays high.
- R9: `rx_ferr` is set when the first stop bit is sampled low.
- R10: `rx_brk` is set when all data bits, the parity bit (if present) and the stop bit are sampled low. Such a character also has `rx_ferr` set.
- R11: After reset `txd` is high and `tx_pop` and `rx_push` are low.
- R12: The start bit is checked again halfway through. A low pulse on `rxd` shorter than that is dropped and produces no character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brg_en | input | 1 | Rate generator enable |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| baud_word | input | BAUD_W | Divisor minus one |
| char_len | input | 2 | Data length code (5 + code bits) |
| two_stop | input | 1 | Two stop bits when 1 |
| tx_par_en | input | 1 | Transmit parity enable |
| tx_par_even | input | 1 | Transmit even parity when 1, odd when 0 |
| rx_par_en | input | 1 | Receive parity enable |
| rx_par_even | input | 1 | Receive even parity when 1, odd when 0 |
| tx_break | input | 1 | Hold line low (break) |
| loopback | input | 1 | Internal loopback |
| tx_valid | input | 1 | Transmit FIFO holds a character |
| tx_data | input | 8 | Character at the head of the transmit FIFO |
| tx_pop | output | 1 | Takes the head character this clock |
| rx_push | output | 1 | One-clock strobe of a received character |
| rx_data | output | 8 | Received character |
| rx_perr | output | 1 | Parity error flag for the pushed character |
| rx_ferr | output | 1 | Framing error flag for the pushed character |
| rx_brk | output | 1 | Break flag for the pushed character |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
Two events can fall on the same tick. The first is the end of one character's last stop bit with the next character already waiting. The bench provokes it by offering a second character while the first is still being sent, then judges the gap between the two pop strobes against the exact frame length for one and for two stop bits. The second is a break request against a transmitter that has a character ready. The bench holds `tx_valid` high while the break is asserted and expects the line to stay low with no pop until the break is released.

// File: rtl/uart_frame_pkg.sv
package uart_frame_pkg;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_START,
        FS_DATA,
        FS_PAR,
        FS_STOP
    } frame_st_e;

    // mask of the data bits in use for a length code
    function automatic logic [7:0] len_mask(input logic [1:0] code);
        return 8'hFF >> (3'd3 - {1'b0, code});
    endfunction

    // index of the last data bit for a length code
    function automatic logic [2:0] last_bit(input logic [1:0] code);
        return {1'b0, code} + 3'd4;
    endfunction

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
    parameter int BAUD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [BAUD_W-1:0] divisor,
    output logic              tick
);
    typedef struct packed {
        logic [BAUD_W-1:0] cnt;
        logic              tick;
    } bg_t;

    bg_t q, d;

    always_comb begin
        d = q;
        d.tick = 1'b0;
        if (!en) begin
            d.cnt = '0;
        end else if (q.cnt >= divisor) begin
            d.cnt  = '0;
            d.tick = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick = q.tick;
endmodule

// File: rtl/uart_tx_ser.sv
module uart_tx_ser
    import uart_frame_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       tx_en,
    input  logic       brk,
    input  logic [1:0] len_code,
    input  logic       two_stop,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_pop,
    output logic       line
);
    localparam int SUB_W = $clog2(OVS);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

    typedef struct packed {
        frame_st_e        st;
        logic [SUB_W-1:0] sub;
        logic [2:0]       bitn;
        logic [7:0]       shreg;
        logic             par;
        logic             stop2;
        logic             line;
    } tx_t;

    tx_t q, d;
    logic       pop;
    logic [7:0] masked;

    always_comb begin
        d      = q;
        pop    = 1'b0;
        masked = tx_data & len_mask(len_code);
        if (q.st == FS_IDLE) begin
            if (tick && tx_en && tx_valid && !brk) begin
                pop     = 1'b1;
                d.st    = FS_START;
                d.sub   = '0;
                d.shreg = masked;
                d.par   = par_even ? ^masked : ~^masked;
            end
        end else if (tick) begin
            d.sub = q.sub + 1'b1;
            if (q.sub == SUB_LAST) begin
                unique case (q.st)
                    FS_START: begin
                        d.st   = FS_DATA;
                        d.bitn = '0;
                    end
                    FS_DATA: begin
                        d.shreg = q.shreg >> 1;
                        d.bitn  = q.bitn + 3'd1;
                        if (q.bitn == last_bit(len_code)) begin
                            d.st    = par_en ? FS_PAR : FS_STOP;
                            d.stop2 = 1'b0;
                        end
                    end
                    FS_PAR: begin
                        d.st    = FS_STOP;
                        d.stop2 = 1'b0;
                    end
                    FS_STOP: begin
                        if (two_stop && !q.stop2) d.stop2 = 1'b1;
                        else                      d.st    = FS_IDLE;
                    end
                    default: d.st = FS_IDLE;
                endcase
            end
        end
        unique case (d.st)
            FS_START: d.line = 1'b0;
            FS_DATA:  d.line = d.shreg[0];
            FS_PAR:   d.line = d.par;
            default:  d.line = 1'b1;
        endcase
        if (brk) d.line = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= FS_IDLE;
            q.line <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_pop = pop;
    assign line   = q.line;
endmodule

// File: rtl/uart_rx_ser.sv
module uart_rx_ser
    import uart_frame_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_en,
    input  logic       rxi,
    input  logic [1:0] len_code,
    input  logic       par_en,
    input  logic       par_even,
    output logic       push,
    output logic [7:0] data,
    output logic       perr,
    output logic       ferr,
    output logic       brk
);
    localparam int SUB_W = $clog2(OVS);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
    localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);

    typedef struct packed {
        frame_st_e        st;
        logic [SUB_W-1:0] sub;
        logic [2:0]       bitn;
        logic [7:0]       data;
        logic             parbit;
        logic             push;
        logic             perr;
        logic             ferr;
        logic             brk;
    } rx_t;

    rx_t  q, d;
    logic par_exp;

    always_comb begin
        d       = q;
        d.push  = 1'b0;
        par_exp = par_even ? ^q.data : ~^q.data;
        if (q.st == FS_IDLE) begin
            if (tick && rx_en && !rxi) begin
                d.st     = FS_START;
                d.sub    = '0;
                d.data   = '0;
                d.parbit = 1'b0;
            end
        end else if (tick) begin
            d.sub = q.sub + 1'b1;
            if (q.st == FS_START) begin
                if (q.sub == SUB_MID) begin
                    d.sub  = '0;
                    d.bitn = '0;
                    d.st   = rxi ? FS_IDLE : FS_DATA;
                end
            end else if (q.sub == SUB_LAST) begin
                unique case (q.st)
                    FS_DATA: begin
                        d.data[q.bitn] = rxi;
                        d.bitn         = q.bitn + 3'd1;
                        if (q.bitn == last_bit(len_code))
                            d.st = par_en ? FS_PAR : FS_STOP;
                    end
                    FS_PAR: begin
                        d.parbit = rxi;
                        d.st     = FS_STOP;
                    end
                    FS_STOP: begin
                        d.push = 1'b1;
                        d.ferr = !rxi;
                        d.perr = par_en && (q.parbit != par_exp);
                        d.brk  = !rxi && (q.data == '0) && !q.parbit;
                        d.st   = FS_IDLE;
                    end
                    default: d.st = FS_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= FS_IDLE;
        end else begin
            q <= d;
        end
    end

    assign push = q.push;
    assign data = q.data;
    assign perr = q.perr;
    assign ferr = q.ferr;
    assign brk  = q.brk;
endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine #(
    parameter int BAUD_W = 16,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              brg_en,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic [BAUD_W-1:0] baud_word,
    input  logic [1:0]        char_len,
    input  logic              two_stop,
    input  logic              tx_par_en,
    input  logic              tx_par_even,
    input  logic              rx_par_en,
    input  logic              rx_par_even,
    input  logic              tx_break,
    input  logic              loopback,
    input  logic              tx_valid,
    input  logic [7:0]        tx_data,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [7:0]        rx_data,
    output logic              rx_perr,
    output logic              rx_ferr,
    output logic              rx_brk,
    input  logic              rxd,
    output logic              txd
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t sq, sd;
    logic  tick, line, rx_in;

    always_comb begin
        sd.s1 = rxd;
        sd.s2 = sq.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq <= '1;
        else        sq <= sd;
    end

    assign rx_in = loopback ? line : sq.s2;
    assign txd   = loopback ? 1'b1 : line;

    uart_baud_gen #(.BAUD_W(BAUD_W)) bg_i (
        .clk(clk), .rst_n(rst_n), .en(brg_en), .divisor(baud_word), .tick(tick)
    );

    uart_tx_ser #(.OVS(OVS)) tx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en), .brk(tx_break),
        .len_code(char_len), .two_stop(two_stop), .par_en(tx_par_en),
        .par_even(tx_par_even), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_pop(tx_pop), .line(line)
    );

    uart_rx_ser #(.OVS(OVS)) rx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_en(rx_en), .rxi(rx_in),
        .len_code(char_len), .par_en(rx_par_en), .par_even(rx_par_even),
        .push(rx_push), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr),
        .brk(rx_brk)
    );
endmodule

// File: rtl/uart_frame_chk.sv
module uart_frame_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       brg_en,
    input logic [1:0] char_len,
    input logic       tx_break,
    input logic       loopback,
    input logic       tx_pop,
    input logic       rx_push,
    input logic [7:0] rx_data,
    input logic       rx_ferr,
    input logic       rx_brk,
    input logic       txd
);
    // R7
    break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_break && $past(tx_break) && !loopback |-> !txd);

    // R10
    brk_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && rx_brk |-> rx_ferr);

    // R1
    len_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && char_len == 2'd0 |-> rx_data[7:5] == 3'b000);

    // R6
    no_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !brg_en && $past(!brg_en) && $past(!brg_en, 2) |-> !tx_pop && !rx_push);

    // R2
    single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> !tx_pop);
endmodule

bind uart_frame_engine uart_frame_chk chk_i (
    .clk(clk), .rst_n(rst_n), .brg_en(brg_en), .char_len(char_len),
    .tx_break(tx_break), .loopback(loopback), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_data(rx_data), .rx_ferr(rx_ferr),
    .rx_brk(rx_brk), .txd(txd)
);

// File: tb/uart_frame_engine_tb_top.sv
module uart_frame_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        brg_en = 1'b1, tx_en = 1'b1, rx_en = 1'b1;
    logic [15:0] baud_word = 16'd1;
    logic [1:0]  char_len = 2'd3;
    logic        two_stop = 1'b0;
    logic        tx_par_en = 1'b0, tx_par_even = 1'b1;
    logic        rx_par_en = 1'b0, rx_par_even = 1'b1;
    logic        tx_break = 1'b0, loopback = 1'b0;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_data = 8'h00;
    logic        rxd = 1'b1;
    logic        tx_pop, rx_push, rx_perr, rx_ferr, rx_brk, txd;
    logic [7:0]  rx_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_frame_engine dut_i (
        .clk(clk), .rst_n(rst_n), .brg_en(brg_en), .tx_en(tx_en), .rx_en(rx_en),
        .baud_word(baud_word), .char_len(char_len), .two_stop(two_stop),
        .tx_par_en(tx_par_en), .tx_par_even(tx_par_even),
        .rx_par_en(rx_par_en), .rx_par_even(rx_par_even),
        .tx_break(tx_break), .loopback(loopback), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_pop(tx_pop), .rx_push(rx_push),
        .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .rx_brk(rx_brk), .rxd(rxd), .txd(txd)
    );

    function automatic int bitc();
        return 16 * (int'(baud_word) + 1);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send_tx(input logic [7:0] d, output int when, output bit ok);
        ok = 1'b0;
        when = 0;
        @(posedge clk); #1;
        tx_valid = 1'b1;
        tx_data  = d;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (tx_pop) begin
                ok = 1'b1;
                when = cyc;
                break;
            end
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
        tx_valid = 1'b0;
    endtask

    task automatic wait_push(input int lim, output bit got, output logic [7:0] d,
                             output bit pe, output bit fe, output bit bk, output int lows);
        got = 1'b0; d = '0; pe = 1'b0; fe = 1'b0; bk = 1'b0; lows = 0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (!txd) lows++;
            if (rx_push) begin
                got = 1'b1; d = rx_data; pe = rx_perr; fe = rx_ferr; bk = rx_brk;
                break;
            end
        end
    endtask

    task automatic drive_frame(input logic [7:0] d, input int nbits, input bit pen,
                               input bit pbit, input bit stopv);
        @(negedge clk);
        rxd = 1'b0;
        repeat (bitc()) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            rxd = d[i];
            repeat (bitc()) @(negedge clk);
        end
        if (pen) begin
            rxd = pbit;
            repeat (bitc()) @(negedge clk);
        end
        rxd = stopv;
        repeat (bitc()) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * bitc()) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11", "txd", int'(txd), 1);
        chk("R11", "tx_pop", int'(tx_pop), 0);
        chk("R11", "rx_push", int'(rx_push), 0);
    endtask

    task automatic t_loop(input logic [1:0] len, input bit pen, input bit even,
                          input logic [7:0] d);
        bit got, ok, pe, fe, bk;
        int when, lows;
        logic [7:0] r;
        char_len = len; tx_par_en = pen; rx_par_en = pen;
        tx_par_even = even; rx_par_even = even; loopback = 1'b1;
        fork
            send_tx(d, when, ok);
            wait_push(20 * bitc(), got, r, pe, fe, bk, lows);
        join
        chk("R8", "char returned", int'(got), 1);
        chk("R1", "data masked to length", int'(r), int'(d & (8'hFF >> (3 - len))));
        chk("R4", "no parity error", int'(pe), 0);
        chk("R9", "no framing error", int'(fe), 0);
        chk("R8", "txd low samples in loopback", lows, 0);
        repeat (4 * bitc()) @(negedge clk);
        loopback = 1'b0; tx_par_en = 1'b0; rx_par_en = 1'b0;
    endtask

    task automatic t_tx_decode(input logic [1:0] len, input bit pen, input bit even,
                               input logic [15:0] bw, input logic [7:0] d);
        bit ok;
        int when;
        int n;
        logic [7:0] m;
        baud_word = bw; char_len = len; tx_par_en = pen; tx_par_even = even;
        n = 5 + int'(len);
        m = d & (8'hFF >> (3 - len));
        send_tx(d, when, ok);
        chk("R5", "pop seen", int'(ok), 1);
        repeat (bitc() / 2) @(negedge clk);
        chk("R5", "start bit low at mid", int'(txd), 0);
        for (int i = 0; i < n; i++) begin
            repeat (bitc()) @(negedge clk);
            if (txd !== m[i]) chk("R1", "data bit", int'(txd), int'(m[i]));
        end
        total++;
        if (pen) begin
            repeat (bitc()) @(negedge clk);
            chk("R3", "parity bit", int'(txd), even ? int'(^m) : int'(~^m));
        end
        repeat (bitc()) @(negedge clk);
        chk("R5", "stop bit high", int'(txd), 1);
        repeat (2 * bitc()) @(negedge clk);
        baud_word = 16'd1; tx_par_en = 1'b0;
    endtask

    task automatic t_gap(input bit two);
        bit ok0, ok1;
        int w0, w1;
        int p;
        char_len = 2'd3; two_stop = two; baud_word = 16'd1;
        p = 2;
        send_tx(8'h33, w0, ok0);
        send_tx(8'hCC, w1, ok1);
        chk("R2", "two pops", int'(ok0 && ok1), 1);
        chk("R2", two ? "gap with two stops" : "gap with one stop", w1 - w0,
            (two ? 11 : 10) * 16 * p + p);
        repeat (13 * bitc()) @(negedge clk);
        two_stop = 1'b0;
    endtask

    task automatic t_rx(input logic [7:0] d, input bit pbit, input bit stopv,
                        input int epe, input int efe, input int ebk, input string req);
        bit got, pe, fe, bk;
        int lows;
        logic [7:0] r;
        fork
            drive_frame(d, 8, rx_par_en, pbit, stopv);
            wait_push(20 * bitc(), got, r, pe, fe, bk, lows);
        join
        chk(req, "push seen", int'(got), 1);
        chk(req, "data", int'(r), int'(d));
        chk(req, "perr", int'(pe), epe);
        chk(req, "ferr", int'(fe), efe);
        chk(req, "brk", int'(bk), ebk);
    endtask

    task automatic t_rx_errors();
        char_len = 2'd3; rx_par_en = 1'b1; rx_par_even = 1'b1;
        t_rx(8'h3C, 1'b0, 1'b1, 0, 0, 0, "R4");
        t_rx(8'h3D, 1'b0, 1'b1, 1, 0, 0, "R4");
        rx_par_even = 1'b0;
        t_rx(8'h3C, 1'b1, 1'b1, 0, 0, 0, "R4");
        rx_par_even = 1'b1;
        t_rx(8'h81, 1'b0, 1'b0, 0, 1, 0, "R9");
        t_rx(8'h00, 1'b0, 1'b0, 0, 1, 1, "R10");
        rx_par_en = 1'b0;
    endtask

    task automatic t_glitch();
        bit got, pe, fe, bk;
        int lows;
        logic [7:0] r;
        @(negedge clk);
        rxd = 1'b0;
        repeat (3 * 2) @(negedge clk);
        rxd = 1'b1;
        wait_push(12 * bitc(), got, r, pe, fe, bk, lows);
        chk("R12", "short low pulse dropped", int'(got), 0);
    endtask

    task automatic t_enables();
        int pops, highs;
        bit got, pe, fe, bk;
        int lows;
        logic [7:0] r;
        brg_en = 1'b0;
        @(posedge clk); #1;
        tx_valid = 1'b1; tx_data = 8'h55;
        pops = 0; highs = 0;
        repeat (200) begin
            @(negedge clk);
            if (tx_pop) pops++;
            if (txd) highs++;
        end
        chk("R6", "pops with rate generator off", pops, 0);
        chk("R6", "line idle with rate generator off", highs, 200);
        brg_en = 1'b1; tx_en = 1'b0;
        pops = 0;
        repeat (200) begin
            @(negedge clk);
            if (tx_pop) pops++;
        end
        chk("R6", "pops with transmitter off", pops, 0);
        tx_valid = 1'b0; tx_en = 1'b1;
        rx_en = 1'b0;
        fork
            drive_frame(8'h5A, 8, 1'b0, 1'b0, 1'b1);
            wait_push(14 * bitc(), got, r, pe, fe, bk, lows);
        join
        chk("R6", "push with receiver off", int'(got), 0);
        rx_en = 1'b1;
    endtask

    task automatic t_break();
        int pops, highs;
        bit ok;
        int when;
        tx_break = 1'b1;
        @(posedge clk); #1;
        tx_valid = 1'b1; tx_data = 8'hF0;
        pops = 0; highs = 0;
        @(negedge clk);
        repeat (300) begin
            @(negedge clk);
            if (tx_pop) pops++;
            if (txd) highs++;
        end
        chk("R7", "pops during break", pops, 0);
        chk("R7", "line high samples during break", highs, 0);
        tx_valid = 1'b0;
        tx_break = 1'b0;
        send_tx(8'hF0, when, ok);
        chk("R7", "pop after break released", int'(ok), 1);
        repeat (12 * bitc()) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_loop(2'd3, 1'b0, 1'b1, 8'hA5);
        t_loop(2'd0, 1'b1, 1'b1, 8'hFF);
        t_loop(2'd1, 1'b1, 1'b0, 8'h2C);
        t_loop(2'd2, 1'b0, 1'b1, 8'h5A);
        t_tx_decode(2'd3, 1'b1, 1'b1, 16'd1, 8'hB7);
        t_tx_decode(2'd0, 1'b1, 1'b0, 16'd3, 8'hEB);
        t_tx_decode(2'd2, 1'b0, 1'b1, 16'd3, 8'h4D);
        t_gap(1'b0);
        t_gap(1'b1);
        t_rx_errors();
        t_glitch();
        t_enables();
        t_break();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule